// File: doc/BRIEF.md
# Port-Mapped ALU with Condition Flags

This block is an 8-bit arithmetic and logic unit that a small processor reaches through its I/O bus at four consecutive port addresses. Software first writes the two operands to their own ports. A write of an operation code to the command port then runs that operation in a single clock. The outcome lands in a result register, which software reads back from the result port.

Three condition flags are driven as plain outputs, so the processor can make its instructions conditional on them. They are greater/carry, smaller and equal. The operations are addition and subtraction through the carry, shifts through the carry, rotates, five bitwise operations, a three-way compare, and increment and decrement. Each operation changes only the flags that belong to it. The other flags keep their values.

Top module: `io_alu`

## Requirements
- R1: The ports sit at fixed addresses. Operand A is at 0xFFFC and operand B is at 0xFFFD. The command port is at 0xFFFE and its readback is the last code written, in bits 3:0. The result is at 0xFFFF. Writes to the result port or to any address outside the four ports change nothing. Reads of any address outside the four ports return 0.
- R2: The result and flags change at the clock edge that accepts the write to the command port, using the operands held at that time. They hold their values in every cycle without such a write.
- R3: Code 0 (add) gives A + B + gt modulo 256. gt becomes the carry out. sm and eq are unchanged.
- R4: Code 1 (subtract) gives A − B − gt modulo 256. gt becomes 1 when A < B + gt, and 0 otherwise. sm and eq are unchanged.
- R5: Code 2 shifts A left and code 3 shifts A right. Both fill the vacated bit with zero. gt takes the bit that was shifted out. sm and eq are unchanged.
- R6: Code 4 rotates A left by one bit and code 5 rotates A right by one bit. The rotate stays within the 8 bits and does not use the carry. All flags are unchanged.
- R7: The bitwise codes are 6 = OR, 7 = AND, 8 = NAND, 9 = XOR and 10 = XNOR, each applied to A and B. All flags are unchanged.
- R8: Code 11 (compare) sets gt = (A > B), sm = (A < B) and eq = (A == B), comparing unsigned. The result register is unchanged.
- R9: Code 12 gives A + 1 and code 13 gives A − 1, both wrapping modulo 256. eq becomes 1 exactly when the new result is zero. gt and sm are unchanged.
- R10: Codes 14 and 15 change neither the result nor any flag.
- R11: The reset is synchronous and active low. It clears both operands, the stored code, the result and all three flags to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | I/O port address |
| bus_wr | input | 1 | Write strobe for the addressed port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed port (combinational) |
| flag_gt | output | 1 | Greater / carry flag |
| flag_sm | output | 1 | Smaller flag |
| flag_eq | output | 1 | Equal / zero flag |

## Verification
Every piece of state can be seen at the ports without delay. Operand, code and result registers read back combinationally, and the flags are wired straight to outputs. A corrupted register therefore shows on the next read of its port. A flag that was written when it should have been kept shows in the cycle right after the command edge, and the next add or subtract carries it further into the result. The stimulus deliberately chains operations so that a wrongly updated flag from one command changes the expected value of a later one.

// File: rtl/io_alu_pkg.sv
// Shared definitions for the port-mapped ALU: command codes, flag bundle,
// port indices. Assumes a 4-bit command field in the low bits of a write.
package io_alu_pkg;

    localparam int unsigned OP_W      = 4;
    localparam int unsigned NUM_PORTS = 4;

    // Port offsets from the base address; order is fixed by the bus map.
    localparam int unsigned PORT_A   = 0;
    localparam int unsigned PORT_B   = 1;
    localparam int unsigned PORT_CMD = 2;
    localparam int unsigned PORT_RES = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_SHL  = 4'd2,
        OP_SHR  = 4'd3,
        OP_ROL  = 4'd4,
        OP_ROR  = 4'd5,
        OP_OR   = 4'd6,
        OP_AND  = 4'd7,
        OP_NAND = 4'd8,
        OP_XOR  = 4'd9,
        OP_XNOR = 4'd10,
        OP_CMP  = 4'd11,
        OP_INC  = 4'd12,
        OP_DEC  = 4'd13
    } alu_op_e;

    typedef struct packed {
        logic gt;
        logic sm;
        logic eq;
    } alu_flags_t;

endpackage

// File: rtl/io_alu_decode.sv
// Address decoder: raises one select per port when the bus address equals
// base + port index. Assumes the four ports do not wrap past the address top.
module io_alu_decode #(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFFFC
) (
    input  logic [ADDR_W-1:0]                   addr_i,
    output logic [io_alu_pkg::NUM_PORTS-1:0]    sel_o
);
    localparam int unsigned NP = io_alu_pkg::NUM_PORTS;

    for (genvar i = 0; i < NP; i++) begin : g_port
        localparam logic [ADDR_W-1:0] PORT_ADDR = BASE_ADDR + ADDR_W'(i);
        // Purpose: full-width compare of the address against this port.
        assign sel_o[i] = (addr_i == PORT_ADDR);
    end
endmodule

// File: rtl/io_alu_exec.sv
// Combinational datapath: from the operands, the command code and the present
// result and flags, forms the next result and flags. Operations that do not
// own a value pass the present one through. Assumes DATA_W >= 2.
module io_alu_exec
    import io_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] res_i,
    input  alu_flags_t        flags_i,
    output logic [DATA_W-1:0] res_o,
    output alu_flags_t        flags_o
);
    localparam int unsigned XW = DATA_W + 1;

    logic [XW-1:0]     sum_x;
    logic [XW-1:0]     diff_x;
    logic [DATA_W-1:0] inc_v;
    logic [DATA_W-1:0] dec_v;

    // Purpose: one extended adder and subtractor with carry-in from gt.
    assign sum_x  = {1'b0, a_i} + {1'b0, b_i} + XW'(flags_i.gt);
    assign diff_x = {1'b0, a_i} - {1'b0, b_i} - XW'(flags_i.gt);
    assign inc_v  = a_i + DATA_W'(1);
    assign dec_v  = a_i - DATA_W'(1);

    // Purpose: select next result and per-flag updates by command code.
    always_comb begin
        res_o   = res_i;
        flags_o = flags_i;
        case (op_i)
            OP_ADD:  begin res_o = sum_x[DATA_W-1:0];  flags_o.gt = sum_x[DATA_W];  end
            OP_SUB:  begin res_o = diff_x[DATA_W-1:0]; flags_o.gt = diff_x[DATA_W]; end
            OP_SHL:  begin res_o = {a_i[DATA_W-2:0], 1'b0}; flags_o.gt = a_i[DATA_W-1]; end
            OP_SHR:  begin res_o = {1'b0, a_i[DATA_W-1:1]}; flags_o.gt = a_i[0]; end
            OP_ROL:  res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
            OP_ROR:  res_o = {a_i[0], a_i[DATA_W-1:1]};
            OP_OR:   res_o = a_i | b_i;
            OP_AND:  res_o = a_i & b_i;
            OP_NAND: res_o = ~(a_i & b_i);
            OP_XOR:  res_o = a_i ^ b_i;
            OP_XNOR: res_o = ~(a_i ^ b_i);
            OP_CMP:  begin
                flags_o.gt = (a_i > b_i);
                flags_o.sm = (a_i < b_i);
                flags_o.eq = (a_i == b_i);
            end
            OP_INC:  begin res_o = inc_v; flags_o.eq = (inc_v == '0); end
            OP_DEC:  begin res_o = dec_v; flags_o.eq = (dec_v == '0); end
            default: ;
        endcase
    end
endmodule

// File: rtl/io_alu.sv
// Top of the port-mapped ALU: operand, command, result and flag registers,
// bus write enables and the read multiplexer. Assumes one bus access per cycle
// and a combinational read path; the command write executes on its own edge.
module io_alu
    import io_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              flag_gt,
    output logic              flag_sm,
    output logic              flag_eq
);
    logic [NUM_PORTS-1:0] sel;
    logic [DATA_W-1:0]    opa_q, opb_q, res_q, res_d;
    logic [OP_W-1:0]      cmd_q;
    alu_flags_t           flags_q, flags_d;
    logic                 cmd_wr;
    logic [OP_W-1:0]      cmd_in;

    io_alu_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .addr_i (bus_addr),
        .sel_o  (sel)
    );

    assign cmd_wr = bus_wr && sel[PORT_CMD];
    assign cmd_in = bus_wdata[OP_W-1:0];

    io_alu_exec #(.DATA_W(DATA_W)) u_exec (
        .op_i    (cmd_in),
        .a_i     (opa_q),
        .b_i     (opb_q),
        .res_i   (res_q),
        .flags_i (flags_q),
        .res_o   (res_d),
        .flags_o (flags_d)
    );

    // Purpose: operand and command registers loaded by bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
            cmd_q <= '0;
        end else if (bus_wr) begin
            if (sel[PORT_A])   opa_q <= bus_wdata;
            if (sel[PORT_B])   opb_q <= bus_wdata;
            if (sel[PORT_CMD]) cmd_q <= cmd_in;
        end
    end

    // Purpose: result and flags take the datapath output on a command write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
        end else if (cmd_wr) begin
            res_q   <= res_d;
            flags_q <= flags_d;
        end
    end

    // Purpose: combinational read of the addressed port, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (sel[PORT_A])   bus_rdata = opa_q;
        if (sel[PORT_B])   bus_rdata = opb_q;
        if (sel[PORT_CMD]) bus_rdata = DATA_W'(cmd_q);
        if (sel[PORT_RES]) bus_rdata = res_q;
    end

    assign flag_gt = flags_q.gt;
    assign flag_sm = flags_q.sm;
    assign flag_eq = flags_q.eq;

    // R1: at most one port decoded for any address.
    assert_one_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R2: without a command write, result and flags hold.
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> ($stable(res_q) && $stable(flags_q)));

    // R6 / R7: rotates and bitwise codes leave every flag alone.
    assert_flags_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_in >= OP_ROL && cmd_in <= OP_XNOR) |=> $stable(flags_q));

    // R8: compare keeps the result and raises exactly one relation flag.
    assert_cmp_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_in == OP_CMP) |=> $stable(res_q));
    assert_cmp_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_in == OP_CMP) |=> ($countones({flag_gt, flag_sm, flag_eq}) == 1));

    // R9: after increment or decrement, eq mirrors a zero result.
    assert_step_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (cmd_in == OP_INC || cmd_in == OP_DEC)) |=> (flag_eq == (res_q == '0)));

    // R10: undefined codes change nothing.
    assert_undef_noop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_in > OP_DEC) |=> ($stable(res_q) && $stable(flags_q)));
endmodule

// File: tb/io_alu_test.sv
`timescale 1ns/1ps
module io_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        flag_gt, flag_sm, flag_eq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    io_alu uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flag_gt(flag_gt), .flag_sm(flag_sm), .flag_eq(flag_eq)
    );

    localparam logic [15:0] AD_A = 16'hFFFC, AD_B = 16'hFFFD,
                            AD_C = 16'hFFFE, AD_R = 16'hFFFF;

    // {A, B, code, expected result, expected gt sm eq}; flags chain in order.
    localparam int NV = 24;
    localparam logic [30:0] VEC [0:NV-1] = '{
        {8'h01, 8'h05, 4'd0,  8'h06, 3'b000},
        {8'h06, 8'h06, 4'd11, 8'h06, 3'b001},
        {8'hFF, 8'h01, 4'd0,  8'h00, 3'b101},
        {8'h10, 8'h20, 4'd0,  8'h31, 3'b001},
        {8'h05, 8'h07, 4'd1,  8'hFE, 3'b101},
        {8'h10, 8'h01, 4'd1,  8'h0E, 3'b001},
        {8'h81, 8'h00, 4'd2,  8'h02, 3'b101},
        {8'h02, 8'h00, 4'd3,  8'h01, 3'b001},
        {8'h03, 8'h00, 4'd3,  8'h01, 3'b101},
        {8'h81, 8'h00, 4'd4,  8'h03, 3'b101},
        {8'h01, 8'h00, 4'd5,  8'h80, 3'b101},
        {8'hF0, 8'h0C, 4'd6,  8'hFC, 3'b101},
        {8'hF0, 8'h3C, 4'd7,  8'h30, 3'b101},
        {8'hF0, 8'h3C, 4'd8,  8'hCF, 3'b101},
        {8'hF0, 8'h3C, 4'd9,  8'hCC, 3'b101},
        {8'hF0, 8'h3C, 4'd10, 8'h33, 3'b101},
        {8'h02, 8'h09, 4'd11, 8'h33, 3'b010},
        {8'h90, 8'h09, 4'd11, 8'h33, 3'b100},
        {8'hFF, 8'h00, 4'd12, 8'h00, 3'b101},
        {8'h41, 8'h00, 4'd12, 8'h42, 3'b100},
        {8'h01, 8'h00, 4'd13, 8'h00, 3'b101},
        {8'h00, 8'h00, 4'd13, 8'hFF, 3'b100},
        {8'h55, 8'h66, 4'd14, 8'hFF, 3'b100},
        {8'hAA, 8'h11, 4'd15, 8'hFF, 3'b100}
    };

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0:        return "R3";
            4'd1:        return "R4";
            4'd2, 4'd3:  return "R5";
            4'd4, 4'd5:  return "R6";
            4'd11:       return "R8";
            4'd12, 4'd13: return "R9";
            4'd14, 4'd15: return "R10";
            default:     return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state on every port and flag
        bus_read(AD_A, rd); check("R11 opA", rd, 8'h00);
        bus_read(AD_B, rd); check("R11 opB", rd, 8'h00);
        bus_read(AD_C, rd); check("R11 cmd", rd, 8'h00);
        bus_read(AD_R, rd); check("R11 res", rd, 8'h00);
        check("R11 flags", {5'b0, flag_gt, flag_sm, flag_eq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [30:0] v;
            v = VEC[i];
            bus_write(AD_A, v[30:23]);
            bus_write(AD_B, v[22:15]);
            bus_write(AD_C, {4'b0, v[14:11]});
            bus_read(AD_R, rd);
            check(tag_of(v[14:11]), rd, v[10:3]);
            check(tag_of(v[14:11]), {5'b0, flag_gt, flag_sm, flag_eq}, {5'b0, v[2:0]});
        end

        // R2: flags change exactly at the edge taking the command write (gt 1 -> 0)
        bus_write(AD_A, 8'h03);
        bus_write(AD_B, 8'h04);
        @(negedge clk);
        bus_addr = AD_C; bus_wdata = 8'h00; bus_wr = 1'b1;
        #1 check("R2 before edge gt", {7'b0, flag_gt}, 8'h01);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R2 after edge gt", {7'b0, flag_gt}, 8'h00);
        bus_read(AD_R, rd); check("R2 R3 add with carry", rd, 8'h08);

        // R1: readback of operand and command ports, unmapped and result writes
        bus_read(AD_A, rd); check("R1 opA readback", rd, 8'h03);
        bus_read(AD_B, rd); check("R1 opB readback", rd, 8'h04);
        bus_read(AD_C, rd); check("R1 cmd readback", rd, 8'h00);
        bus_write(16'hFFFB, 8'hAA);
        bus_read(16'hFFFB, rd); check("R1 unmapped read", rd, 8'h00);
        bus_read(AD_A, rd); check("R1 unmapped write opA", rd, 8'h03);
        bus_write(AD_R, 8'h77);
        bus_read(AD_R, rd); check("R1 result write ignored", rd, 8'h08);
        bus_write(16'h0000, 8'h55);
        bus_read(AD_B, rd); check("R1 low address write opB", rd, 8'h04);

        // R11: reset during operation clears result and flags
        bus_write(AD_C, 8'd11);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        bus_read(AD_R, rd); check("R11 res after reset", rd, 8'h00);
        check("R11 flags after reset", {5'b0, flag_gt, flag_sm, flag_eq}, 8'h00);
        bus_read(AD_A, rd); check("R11 opA after reset", rd, 8'h00);

        finish_run();
    end
endmodule